// File: doc/BRIEF.md
# Single-Bus Multicycle CPU Core

This block is a small multicycle processor core. All of its internal storage hangs off one shared bus: four general registers, the program counter, the memory address register, the memory data register, a temporary operand register that feeds the ALU, and an ALU result register. A hardwired state machine picks one bus source per cycle and raises the load enables and ALU operation code for that cycle. Incrementing the program counter also goes through the ALU and costs a bus transfer, because the core has no separate incrementer.

The core recognises three instructions: a register add, a two-word subroutine call and a halt. Between two instructions it samples a level interrupt request. When the request is taken, the core writes the program counter to a fixed save address and then continues fetching at a fixed vector address. Memory is a synchronous word-addressed port. A read first loads the address register and then captures the word in the data register one cycle later. A write stores the data register at the address register. A register-select input lets the surrounding logic observe any general register.

Top module: `sbus_cpu`

## Requirements
- R1: While reset is held, and at the first edge after it, all general registers read 0, `halted` is 0 and neither memory strobe is active. The first instruction fetch starts with `instrStart` high and reads address RESET_PC (default 0).
- R2: Every memory read spans two cycles. In the first cycle the address register is loaded. In the second cycle `memRead` is high with `memAddr` equal to the fetched location. `memRead` is never high in two consecutive cycles, and it is never high together with `memWrite`.
- R3: An instruction word with bits [15:12]=0 is an add. It performs Rd <= Rd + Rs modulo 2^DATA_W, where d is bits [11:10] and s is bits [9:8]. Any other register is unchanged, and d equal to s doubles the register.
- R4: An add takes exactly 6 cycles from one `instrStart` pulse to the next: 3 for fetch and 3 for execution. `instrStart` is a one-cycle pulse.
- R5: An instruction word with bits [15:12]=1 is a call. For a call at address A, it sets Rd (bits [11:10]) to A+2 and loads the PC with the word at A+1. It takes 6 cycles, and the next fetch reads the loaded address.
- R6: An opcode of 2 or more halts the core. `halted` then stays high and no memory strobe occurs again. An interrupt request raised while halted is ignored.
- R7: A pending `irqReq` is taken only at an instruction boundary. Entry takes 4 cycles and makes a single write of the next instruction's address to SAVE_ADDR (default 0x00F0). Fetch then resumes at VEC_ADDR (default 0x0080).
- R8: `regVal` always shows the general register selected by `regSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 1 | Level interrupt request, sampled between instructions |
| regSel | input | 2 | Selects the general register shown on regVal |
| memRData | input | DATA_W | Word read from memory at memAddr |
| memAddr | output | DATA_W | Memory word address (address register) |
| memWData | output | DATA_W | Memory write data (data register) |
| memRead | output | 1 | Read strobe; data is captured at the end of this cycle |
| memWrite | output | 1 | Write strobe; memory stores memWData at memAddr |
| regVal | output | DATA_W | Contents of the selected general register |
| instrStart | output | 1 | High in the first cycle of every instruction fetch |
| halted | output | 1 | Core has executed a halt |

## Verification
The main program chains two calls and then five adds. The adds use distinct source and destination registers, a source equal to the destination, a destination of R0 and a register that still holds zero. Together these separate a correct field decode from swapped or mis-sliced fields, and a correct result from a write to the wrong register. After each instruction the bench checks the cycle count and the address of the next fetch. This separates an increment routed through the ALU from a lost or doubled increment, and a followed call target from a fall-through. A second program raises the interrupt in the first cycle of an instruction. The total of 10 cycles shows that entry waited for the boundary, and the saved word and the vector fetch show that the correct PC value was stored.

// File: rtl/sbus_cpu_pkg.sv
package sbus_cpu_pkg;

  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int OPC_W     = 4;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_REG, BUS_PC, BUS_MDR, BUS_RES, BUS_SAVE, BUS_VEC
  } busSrcT;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_INC, ALU_ADD
  } aluOpT;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    busSrcT busSrc;
    logic   rdUseDst;   // register bus source: 1 = dst field, 0 = src field
    logic   regWrite;   // write bus into register named by dst field
    logic   pcLoad;
    logic   marLoad;
    logic   mdrFromBus;
    logic   mdrFromMem;
    logic   irLoad;
    logic   tmpLoad;
    logic   resLoad;
    aluOpT  aluOp;
    logic   memRead;
    logic   memWrite;
  } ctrlT;

endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [OPC_W-1:0] opcode,
  output ctrlT             ctrl,
  output logic             instrStart,
  output logic             halted
);

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2,
    S_A0, S_A1, S_A2,
    S_C0, S_C1, S_C2,
    S_I0, S_I1, S_I2, S_I3,
    S_HALT
  } stateT;

  stateT state, stateNext, boundary;

  assign boundary = irqReq ? S_I0 : S_F0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_F0;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_F0: stateNext = S_F1;
      S_F1: stateNext = S_F2;
      S_F2: begin
        if      (opcode == OPC_W'(0)) stateNext = S_A0;
        else if (opcode == OPC_W'(1)) stateNext = S_C0;
        else                          stateNext = S_HALT;
      end
      S_A0: stateNext = S_A1;
      S_A1: stateNext = S_A2;
      S_A2: stateNext = boundary;
      S_C0: stateNext = S_C1;
      S_C1: stateNext = S_C2;
      S_C2: stateNext = boundary;
      S_I0: stateNext = S_I1;
      S_I1: stateNext = S_I2;
      S_I2: stateNext = S_I3;
      S_I3: stateNext = boundary;
      S_HALT: stateNext = S_HALT;
      default: stateNext = S_F0;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.busSrc = BUS_NONE;
    ctrl.aluOp  = ALU_PASS;
    unique case (state)
      S_F0, S_C0: begin          // MAR <= PC, RES <= PC + 1
        ctrl.busSrc  = BUS_PC;
        ctrl.marLoad = 1'b1;
        ctrl.resLoad = 1'b1;
        ctrl.aluOp   = ALU_INC;
      end
      S_F1: begin                // MDR <= M[MAR], PC <= RES
        ctrl.memRead    = 1'b1;
        ctrl.mdrFromMem = 1'b1;
        ctrl.busSrc     = BUS_RES;
        ctrl.pcLoad     = 1'b1;
      end
      S_F2: begin                // IR <= MDR
        ctrl.busSrc = BUS_MDR;
        ctrl.irLoad = 1'b1;
      end
      S_A0: begin                // TMP <= Rs
        ctrl.busSrc  = BUS_REG;
        ctrl.tmpLoad = 1'b1;
      end
      S_A1: begin                // RES <= TMP + Rd
        ctrl.busSrc   = BUS_REG;
        ctrl.rdUseDst = 1'b1;
        ctrl.resLoad  = 1'b1;
        ctrl.aluOp    = ALU_ADD;
      end
      S_A2: begin                // Rd <= RES
        ctrl.busSrc   = BUS_RES;
        ctrl.regWrite = 1'b1;
      end
      S_C1: begin                // MDR <= M[MAR], Rd <= RES
        ctrl.memRead    = 1'b1;
        ctrl.mdrFromMem = 1'b1;
        ctrl.busSrc     = BUS_RES;
        ctrl.regWrite   = 1'b1;
      end
      S_C2: begin                // PC <= MDR
        ctrl.busSrc = BUS_MDR;
        ctrl.pcLoad = 1'b1;
      end
      S_I0: begin                // MDR <= PC
        ctrl.busSrc     = BUS_PC;
        ctrl.mdrFromBus = 1'b1;
      end
      S_I1: begin                // MAR <= save address
        ctrl.busSrc  = BUS_SAVE;
        ctrl.marLoad = 1'b1;
      end
      S_I2: begin                // PC <= vector
        ctrl.busSrc = BUS_VEC;
        ctrl.pcLoad = 1'b1;
      end
      S_I3: ctrl.memWrite = 1'b1;
      default: ;
    endcase
  end

  assign instrStart = (state == S_F0);
  assign halted     = (state == S_HALT);

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_cpu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_PC  = 16'h0000,
  parameter logic [DATA_W-1:0] SAVE_ADDR = 16'h00F0,
  parameter logic [DATA_W-1:0] VEC_ADDR  = 16'h0080
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlT                 ctrl,
  input  logic [REG_IDX_W-1:0] regSel,
  input  logic [DATA_W-1:0]    memRData,
  output logic [OPC_W-1:0]     opcode,
  output logic [DATA_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWData,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [DATA_W-1:0]    regVal
);

  localparam int DST_LSB = 10;
  localparam int SRC_LSB = 8;
  localparam int OPC_LSB = 12;

  logic [DATA_W-1:0]    regFile [NUM_REGS];
  logic [DATA_W-1:0]    pcQ, marQ, mdrQ, tmpQ, resQ;
  logic [REG_IDX_W-1:0] dstQ, srcQ;
  logic [DATA_W-1:0]    busVal, aluOut;
  logic [REG_IDX_W-1:0] rdIdx;

  assign rdIdx = ctrl.rdUseDst ? dstQ : srcQ;

  // Single shared bus: exactly one source per cycle
  always_comb begin
    unique case (ctrl.busSrc)
      BUS_REG:  busVal = regFile[rdIdx];
      BUS_PC:   busVal = pcQ;
      BUS_MDR:  busVal = mdrQ;
      BUS_RES:  busVal = resQ;
      BUS_SAVE: busVal = SAVE_ADDR;
      BUS_VEC:  busVal = VEC_ADDR;
      default:  busVal = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_INC: aluOut = busVal + DATA_W'(1);
      ALU_ADD: aluOut = tmpQ + busVal;
      default: aluOut = busVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      marQ <= '0;
      mdrQ <= '0;
      tmpQ <= '0;
      resQ <= '0;
      dstQ <= '0;
      srcQ <= '0;
    end else begin
      if (ctrl.pcLoad)     pcQ  <= busVal;
      if (ctrl.marLoad)    marQ <= busVal;
      if (ctrl.mdrFromMem) mdrQ <= memRData;
      else if (ctrl.mdrFromBus) mdrQ <= busVal;
      if (ctrl.tmpLoad)    tmpQ <= busVal;
      if (ctrl.resLoad)    resQ <= aluOut;
      if (ctrl.irLoad) begin
        dstQ <= busVal[DST_LSB +: REG_IDX_W];
        srcQ <= busVal[SRC_LSB +: REG_IDX_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (ctrl.regWrite && dstQ == REG_IDX_W'(g))
        regFile[g] <= busVal;
    end
  end

  assign opcode   = mdrQ[OPC_LSB +: OPC_W];
  assign memAddr  = marQ;
  assign memWData = mdrQ;
  assign memRead  = ctrl.memRead;
  assign memWrite = ctrl.memWrite;
  assign regVal   = regFile[regSel];

endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
  import sbus_cpu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_PC  = 16'h0000,
  parameter logic [DATA_W-1:0] SAVE_ADDR = 16'h00F0,
  parameter logic [DATA_W-1:0] VEC_ADDR  = 16'h0080
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] regVal,
  output logic              instrStart,
  output logic              halted
);

  ctrlT             ctrl;
  logic [OPC_W-1:0] opcode;

  sbus_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .opcode     (opcode),
    .ctrl       (ctrl),
    .instrStart (instrStart),
    .halted     (halted)
  );

  sbus_datapath #(
    .DATA_W    (DATA_W),
    .RESET_PC  (RESET_PC),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .regSel   (regSel),
    .memRData (memRData),
    .opcode   (opcode),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memRead  (memRead),
    .memWrite (memWrite),
    .regVal   (regVal)
  );

endmodule

// File: rtl/sbus_cpu_chk.sv
module sbus_cpu_chk #(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] SAVE_ADDR = 16'h00F0
)(
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              memRead,
  input logic              memWrite,
  input logic [DATA_W-1:0] memAddr,
  input logic              instrStart,
  input logic              halted
);

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));                                       // R2
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    memRead |=> !memRead);                                         // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    instrStart |=> !instrStart);                                   // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !memRead && !memWrite));                 // R6
  AST_SAVE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> memAddr == SAVE_ADDR);                            // R7
  AST_RESUME_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && !irqReq) |=> instrStart);                         // R7
  AST_START_NOT_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    instrStart |-> !halted);                                       // R1

endmodule

bind sbus_cpu sbus_cpu_chk #(.DATA_W(DATA_W), .SAVE_ADDR(SAVE_ADDR)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .irqReq     (irqReq),
  .memRead    (memRead),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .instrStart (instrStart),
  .halted     (halted)
);

// File: tb/sbus_cpu_tb.sv
`timescale 1ns/1ps
module sbus_cpu_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irqReq = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [DW-1:0] memRData, memAddr, memWData, regVal;
  logic          memRead, memWrite, instrStart, halted;

  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign memRData = mem[memAddr[7:0]];
  always @(posedge clk) if (memWrite) mem[memAddr[7:0]] <= memWData;

  sbus_cpu u_dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regSel(regSel),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .memRead(memRead), .memWrite(memWrite), .regVal(regVal),
    .instrStart(instrStart), .halted(halted)
  );

  // cycles, R0..R3 after the instruction, next fetch address
  typedef struct packed {
    logic [7:0]  cyc;
    logic [15:0] r0, r1, r2, r3;
    logic [15:0] nextPc;
  } vecT;

  localparam vecT VECS [7] = '{
    '{8'd6, 16'd0, 16'd2,  16'd0, 16'd0, 16'h0002},  // call R1 @0 -> 2   (R5)
    '{8'd6, 16'd0, 16'd2,  16'd4, 16'd0, 16'h0010},  // call R2 @2 -> 0x10 (R5)
    '{8'd6, 16'd0, 16'd6,  16'd4, 16'd0, 16'h0011},  // add R1,R2 (R3)
    '{8'd6, 16'd0, 16'd6,  16'd8, 16'd0, 16'h0012},  // add R2,R2 (R3)
    '{8'd6, 16'd6, 16'd6,  16'd8, 16'd0, 16'h0013},  // add R0,R1 (R3)
    '{8'd6, 16'd6, 16'd6,  16'd8, 16'd0, 16'h0014},  // add R3,R3 (R3)
    '{8'd6, 16'd6, 16'd12, 16'd8, 16'd0, 16'h0015}   // add R1,R1 (R3)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkRegs(input string req, input logic [15:0] e0, e1, e2, e3);
    logic [15:0] exp [4];
    exp = '{e0, e1, e2, e3};
    for (int i = 0; i < 4; i++) begin
      regSel = 2'(i);
      #0.2;
      check(req, regVal, exp[i]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runToStart(input int start, output int n);
    n = start;
    do begin
      step();
      n++;
      if (memWrite) irqReq = 1'b0;
    end while (!instrStart && n < 100);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    irqReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 read strobe in reset", memRead, 0);
    check("R1 write strobe in reset", memWrite, 0);
    check("R1 halted in reset", halted, 0);
    rstN = 1'b1;
    #0.1;
  endtask

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = 16'h1400; mem[8'h01] = 16'h0002;  // call R1
    mem[8'h02] = 16'h1800; mem[8'h03] = 16'h0010;  // call R2
    mem[8'h10] = 16'h0600;                          // add R1,R2
    mem[8'h11] = 16'h0A00;                          // add R2,R2
    mem[8'h12] = 16'h0100;                          // add R0,R1
    mem[8'h13] = 16'h0F00;                          // add R3,R3
    mem[8'h14] = 16'h0500;                          // add R1,R1
    mem[8'h15] = 16'h2000;                          // halt

    doReset();
    check("R1 fetch start after reset", instrStart, 1);
    check("R2 no read in first fetch cycle", memRead, 0);
    checkRegs("R1 R8 registers after reset", 16'd0, 16'd0, 16'd0, 16'd0);
    step();
    check("R2 read strobe in second cycle", memRead, 1);
    check("R1 R2 first fetch address", memAddr, 16'h0000);

    for (int k = 0; k < 7; k++) begin
      runToStart(1, n);
      check(k < 2 ? "R5 call cycle count" : "R4 add cycle count", n, VECS[k].cyc);
      checkRegs(k < 2 ? "R5 R8 call link register" : "R3 R8 add result",
                VECS[k].r0, VECS[k].r1, VECS[k].r2, VECS[k].r3);
      step();
      check("R2 read strobe on fetch", memRead, 1);
      check(k < 2 ? "R5 next fetch address" : "R2 next fetch address",
            memAddr, VECS[k].nextPc);
    end

    step();
    step();
    check("R6 halted after halt opcode", halted, 1);
    irqReq = 1'b1;
    for (int c = 0; c < 12; c++) begin
      step();
      check("R6 no memory strobe while halted", {30'd0, memRead, memWrite}, 0);
      check("R6 halted remains set", halted, 1);
    end
    check("R6 save slot untouched while halted", mem[8'hF0], 16'h0000);
    irqReq = 1'b0;

    // interrupt program
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = 16'h0000;  // add R0,R0
    mem[8'h01] = 16'h2000;  // halt
    mem[8'h80] = 16'h2000;  // halt at vector
    mem[8'hF0] = 16'hDEAD;
    doReset();
    check("R1 fetch start after second reset", instrStart, 1);
    irqReq = 1'b1;
    runToStart(0, n);
    check("R7 add plus entry cycle count", n, 10);
    check("R7 saved PC at save address", mem[8'hF0], 16'h0001);
    step();
    check("R7 fetch from vector", memAddr, 16'h0080);
    check("R7 read strobe at vector fetch", memRead, 1);
    step();
    step();
    check("R7 vector halt executed", halted, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule